// File: doc/BRIEF.md
# Host Register Port with Interrupt Controller

This block is the host-facing slave port of a larger processing engine. A host drives an active-low select, an active-low write strobe, a 22-bit word address, 32-bit write data and four byte enables. Writes land on the rising clock edge and update only the enabled bytes. A read request is answered one cycle later: the read data is registered, and an active-low drive indication is asserted in the same cycle. External logic can use that indication to enable tristate buffers on a shared bus.

The port holds a small bank of general control words whose values are presented on a flat output bus to the rest of the chip. It also holds an interrupt controller. Internal event sources pulse single-cycle inputs, and each pulse sets a sticky bit in a status register. The host clears status bits by writing ones to them. A mask register selects which status bits may raise the registered, active-low interrupt request.

Address map (word addresses): control word i sits at address i for i below NUM_CTRL (default 4). Interrupt status is at 0x10 and interrupt mask is at 0x11. Status and mask occupy bits [NUM_EVT-1:0] (default 8), and their upper bits read as zero. Every other address is unmapped.

Top module: `hreg_port`

## Requirements
- R1: A write (cs_n=0, wr_n=0 at a rising edge) to control word i updates exactly the bytes whose be bit is set (be[k] covers bits 8k+7:8k). The other bytes keep their value. The result appears on ctrl_o word i after that edge.
- R2: A read request issued in the cycle right after a write to the same address returns the newly written value.
- R3: A read request (cs_n=0, wr_n=1 at a rising edge) makes rdata hold the addressed register's value, as it stood before that edge, for the following cycle. rdata is zero in every cycle that does not follow a read request.
- R4: drv_n is low exactly in the cycles that follow a read request, and high otherwise.
- R5: A high pulse on evt[j] sets status bit j. The bit stays set until the host clears it.
- R6: Writing the status address clears each status bit whose write-data bit is 1 within an enabled byte. Zero bits and disabled bytes leave bits unchanged. An event arriving in the same cycle as its clear leaves the bit set.
- R7: The mask register is written with byte enables and reads back at 0x11. irq_n is low in the cycle after any status bit and its mask bit are both 1, and high otherwise.
- R8: A read of an unmapped address returns zero, with drv_n still asserted. A write to an unmapped address changes no register.
- R9: An asynchronous low on rst_n at once clears all registers and sets rdata=0, drv_n=1 and irq_n=1.
- R10: srst high at a rising edge clears all registers and gives rdata=0, drv_n=1 and irq_n=1 after that edge. Any access or event in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| srst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Register select, active low |
| wr_n | input | 1 | Write strobe, active low (high = read) |
| addr | input | 22 | Word address |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte write enables |
| evt | input | NUM_EVT | Event pulses to the interrupt status |
| rdata | output | 32 | Registered read data |
| drv_n | output | 1 | Read data valid / bus drive enable, active low |
| irq_n | output | 1 | Interrupt request, active low, registered |
| ctrl_o | output | NUM_CTRL*32 | Control word values, word i at bits 32i+31:32i |

## Verification
The assertions check the read handshake on every cycle: drv_n follows each read request by one cycle, and rdata is zero whenever drv_n is high. They also check that status bits latch their events, that irq_n tracks the masked status one cycle later, and that the synchronous reset clears the state. Only the bench's scenarios can show that byte enables leave the right bytes untouched and that read values match the written contents. The same holds for the write-one-to-clear rule against a coincident event, the effect of unmapped accesses, and the immediate effect of the asynchronous reset.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
    localparam int DW   = 32;
    localparam int AW   = 22;
    localparam int BE_W = DW / 8;

    // expand byte enables to a bit mask
    function automatic logic [DW-1:0] be_mask(input logic [BE_W-1:0] be);
        logic [DW-1:0] m;
        for (int k = 0; k < BE_W; k++) begin
            m[8*k +: 8] = {8{be[k]}};
        end
        return m;
    endfunction

    // replace enabled bytes of old with new
    function automatic logic [DW-1:0] be_merge(input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] new_v,
                                               input logic [BE_W-1:0] be);
        logic [DW-1:0] m;
        m = be_mask(be);
        return (old_v & ~m) | (new_v & m);
    endfunction
endpackage

// File: rtl/hreg_decode.sv
module hreg_decode
    import hreg_pkg::*;
#(
    parameter int          NUM_CTRL  = 4,
    parameter logic [AW-1:0] STAT_ADDR = 22'h10,
    parameter logic [AW-1:0] MASK_ADDR = 22'h11
) (
    input  logic [AW-1:0]       addr,
    output logic [NUM_CTRL-1:0] ctrl_hit,
    output logic                stat_hit,
    output logic                mask_hit
);
    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_hit
        assign ctrl_hit[i] = (addr == AW'(i));
    end

    assign stat_hit = (addr == STAT_ADDR);
    assign mask_hit = (addr == MASK_ADDR);
endmodule

// File: rtl/hreg_ctrl_bank.sv
module hreg_ctrl_bank
    import hreg_pkg::*;
#(
    parameter int NUM_CTRL = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   srst,
    input  logic                   wr_en,
    input  logic [NUM_CTRL-1:0]    hit,
    input  logic [DW-1:0]          wdata,
    input  logic [BE_W-1:0]        be,
    output logic [NUM_CTRL*DW-1:0] words
);
    typedef struct packed {
        logic [NUM_CTRL-1:0][DW-1:0] regs;
    } bank_s;

    bank_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (wr_en && hit[i]) begin
                st_d.regs[i] = be_merge(st_q.regs[i], wdata, be);
            end
        end
        if (srst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign words = st_q.regs;
endmodule

// File: rtl/hreg_irq.sv
module hreg_irq
    import hreg_pkg::*;
#(
    parameter int NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               srst,
    input  logic               wr_en,
    input  logic               stat_hit,
    input  logic               mask_hit,
    input  logic [DW-1:0]      wdata,
    input  logic [BE_W-1:0]    be,
    input  logic [NUM_EVT-1:0] evt,
    output logic [NUM_EVT-1:0] stat,
    output logic [NUM_EVT-1:0] mask,
    output logic               irq_n
);
    typedef struct packed {
        logic [NUM_EVT-1:0] stat;
        logic [NUM_EVT-1:0] mask;
        logic               irq_n;
    } irq_s;

    localparam irq_s RST_VAL = '{stat: '0, mask: '0, irq_n: 1'b1};

    irq_s               st_d, st_q;
    logic [NUM_EVT-1:0] clr_w;

    always_comb begin
        st_d  = st_q;
        clr_w = '0;
        if (wr_en && mask_hit) begin
            st_d.mask = NUM_EVT'(be_merge(DW'(st_q.mask), wdata, be));
        end
        if (wr_en && stat_hit) begin
            clr_w = NUM_EVT'(wdata & be_mask(be));
        end
        // a new event wins over a coincident clear
        st_d.stat  = (st_q.stat & ~clr_w) | evt;
        st_d.irq_n = ~|(st_q.stat & st_q.mask);
        if (srst) begin
            st_d = RST_VAL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat  = st_q.stat;
    assign mask  = st_q.mask;
    assign irq_n = st_q.irq_n;
endmodule

// File: rtl/hreg_port.sv
module hreg_port
    import hreg_pkg::*;
#(
    parameter int              NUM_CTRL  = 4,
    parameter int              NUM_EVT   = 8,
    parameter logic [AW-1:0]   STAT_ADDR = 22'h10,
    parameter logic [AW-1:0]   MASK_ADDR = 22'h11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   srst,
    input  logic                   cs_n,
    input  logic                   wr_n,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          wdata,
    input  logic [BE_W-1:0]        be,
    input  logic [NUM_EVT-1:0]     evt,
    output logic [DW-1:0]          rdata,
    output logic                   drv_n,
    output logic                   irq_n,
    output logic [NUM_CTRL*DW-1:0] ctrl_o
);
    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          drv_n;
    } rd_s;

    localparam rd_s RD_RST = '{rdata: '0, drv_n: 1'b1};

    logic                wr_en, rd_en;
    logic [NUM_CTRL-1:0] ctrl_hit;
    logic                stat_hit, mask_hit;
    logic [NUM_EVT-1:0]  irq_stat, irq_mask;
    logic [DW-1:0]       rd_val;
    rd_s                 rd_d, rd_q;

    assign wr_en = !cs_n && !wr_n;
    assign rd_en = !cs_n &&  wr_n;

    hreg_decode #(
        .NUM_CTRL (NUM_CTRL),
        .STAT_ADDR(STAT_ADDR),
        .MASK_ADDR(MASK_ADDR)
    ) dec_i (
        .addr    (addr),
        .ctrl_hit(ctrl_hit),
        .stat_hit(stat_hit),
        .mask_hit(mask_hit)
    );

    hreg_ctrl_bank #(
        .NUM_CTRL(NUM_CTRL)
    ) bank_i (
        .clk  (clk),
        .rst_n(rst_n),
        .srst (srst),
        .wr_en(wr_en),
        .hit  (ctrl_hit),
        .wdata(wdata),
        .be   (be),
        .words(ctrl_o)
    );

    hreg_irq #(
        .NUM_EVT(NUM_EVT)
    ) irq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .srst    (srst),
        .wr_en   (wr_en),
        .stat_hit(stat_hit),
        .mask_hit(mask_hit),
        .wdata   (wdata),
        .be      (be),
        .evt     (evt),
        .stat    (irq_stat),
        .mask    (irq_mask),
        .irq_n   (irq_n)
    );

    // read multiplexer: one-hot hits OR-ed together, unmapped gives zero
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (ctrl_hit[i]) begin
                rd_val = rd_val | ctrl_o[DW*i +: DW];
            end
        end
        if (stat_hit) begin
            rd_val = rd_val | DW'(irq_stat);
        end
        if (mask_hit) begin
            rd_val = rd_val | DW'(irq_mask);
        end
    end

    always_comb begin
        rd_d       = RD_RST;
        if (rd_en) begin
            rd_d.rdata = rd_val;
            rd_d.drv_n = 1'b0;
        end
        if (srst) begin
            rd_d = RD_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= RD_RST;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q.rdata;
    assign drv_n = rd_q.drv_n;
endmodule

// File: rtl/hreg_port_chk.sv
module hreg_port_chk #(
    parameter int NUM_EVT = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               srst,
    input logic               cs_n,
    input logic               wr_n,
    input logic [NUM_EVT-1:0] evt,
    input logic [31:0]        rdata,
    input logic               drv_n,
    input logic               irq_n,
    input logic [NUM_EVT-1:0] stat,
    input logic [NUM_EVT-1:0] mask
);
    a_r4_drv_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && wr_n && !srst) |=> !drv_n);

    a_r4_drv_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cs_n && wr_n) |=> drv_n);

    a_r3_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        drv_n |-> (rdata == '0));

    a_r5_event_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && |evt) |=> ((stat & $past(evt)) == $past(evt)));

    a_r7_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && |(stat & mask)) |=> !irq_n);

    a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & mask) == '0) |=> irq_n);

    a_r10_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (stat == '0 && mask == '0 && drv_n && irq_n && rdata == '0));
endmodule

bind hreg_port hreg_port_chk #(.NUM_EVT(NUM_EVT)) chk_i (
    .clk  (clk),
    .rst_n(rst_n),
    .srst (srst),
    .cs_n (cs_n),
    .wr_n (wr_n),
    .evt  (evt),
    .rdata(rdata),
    .drv_n(drv_n),
    .irq_n(irq_n),
    .stat (irq_stat),
    .mask (irq_mask)
);

// File: tb/hreg_port_tb_top.sv
`timescale 1ns/1ps
module hreg_port_tb_top;
    localparam int NC = 4;
    localparam int NE = 8;
    localparam logic [21:0] A_STAT = 22'h10;
    localparam logic [21:0] A_MASK = 22'h11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          srst = 1'b0;
    logic          cs_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [21:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [3:0]    be = '0;
    logic [NE-1:0] evt = '0;
    logic [31:0]   rdata;
    logic          drv_n;
    logic          irq_n;
    logic [NC*32-1:0] ctrl_o;

    always #4 clk = ~clk;

    hreg_port dut_i (
        .clk(clk), .rst_n(rst_n), .srst(srst), .cs_n(cs_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .be(be), .evt(evt),
        .rdata(rdata), .drv_n(drv_n), .irq_n(irq_n), .ctrl_o(ctrl_o)
    );

    int unsigned nvec = 0;
    int unsigned nbad = 0;
    bit          done = 0;

    logic [31:0]   m_ctrl [NC];
    logic [NE-1:0] m_stat, m_mask;

    function automatic logic [31:0] f_merge(logic [31:0] o, logic [31:0] n, logic [3:0] b);
        logic [31:0] r = o;
        for (int k = 0; k < 4; k++) if (b[k]) r[8*k +: 8] = n[8*k +: 8];
        return r;
    endfunction

    function automatic logic [31:0] f_read(logic [21:0] a);
        if (a < 22'(NC)) return m_ctrl[a[1:0]];
        if (a == A_STAT) return 32'(m_stat);
        if (a == A_MASK) return 32'(m_mask);
        return 32'h0;
    endfunction

    task automatic m_clear();
        for (int i = 0; i < NC; i++) m_ctrl[i] = '0;
        m_stat = '0;
        m_mask = '0;
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_ctrl(string tag);
        for (int i = 0; i < NC; i++) chk(tag, "ctrl_o", ctrl_o[32*i +: 32], m_ctrl[i]);
    endtask

    // one clock: drive at negedge, update model at posedge, compare at next negedge
    task automatic step(string tag, logic c, logic w, logic [21:0] a, logic [31:0] d,
                        logic [3:0] b, logic [NE-1:0] e, logic s);
        logic [31:0]   x_rd;
        logic          x_drv, x_irq;
        logic [NE-1:0] clr;
        bit            rd, wr;
        rd = !c && w;
        wr = !c && !w;
        x_rd  = (rd && !s) ? f_read(a) : 32'h0;
        x_drv = !(rd && !s);
        x_irq = s ? 1'b1 : ~|(m_stat & m_mask);
        cs_n = c; wr_n = w; addr = a; wdata = d; be = b; evt = e; srst = s;
        @(posedge clk);
        if (s) begin
            m_clear();
        end else begin
            clr = '0;
            if (wr && a < 22'(NC)) m_ctrl[a[1:0]] = f_merge(m_ctrl[a[1:0]], d, b);
            if (wr && a == A_MASK) m_mask = NE'(f_merge(32'(m_mask), d, b));
            if (wr && a == A_STAT) clr = NE'(f_merge(32'h0, d, b));
            m_stat = (m_stat & ~clr) | e;
        end
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1; evt = '0; srst = 1'b0;
        chk(tag, "rdata", rdata, x_rd);
        chk("R4", "drv_n", 32'(drv_n), 32'(x_drv));
        chk("R7", "irq_n", 32'(irq_n), 32'(x_irq));
        check_ctrl(tag);
    endtask

    task automatic idle(string tag);
        step(tag, 1'b1, 1'b1, 22'h0, 32'h0, 4'h0, '0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: state after reset
        chk("R9", "rdata", rdata, 32'h0);
        chk("R9", "drv_n", 32'(drv_n), 32'h1);
        chk("R9", "irq_n", 32'(irq_n), 32'h1);
        check_ctrl("R9");

        // R1 / R2: full write then read back next cycle
        step("R1", 1'b0, 1'b0, 22'h0, 32'hA5A5_1234, 4'hF, '0, 1'b0);
        step("R2", 1'b0, 1'b1, 22'h0, 32'h0, 4'h0, '0, 1'b0);
        // R1: partial byte write keeps upper bytes
        step("R1", 1'b0, 1'b0, 22'h1, 32'hFFFF_FFFF, 4'b0011, '0, 1'b0);
        step("R1", 1'b0, 0, 22'h0, 32'h5A5A_0000, 4'b1100, '0, 1'b0);
        step("R3", 1'b0, 1'b1, 22'h1, 32'h0, 4'h0, '0, 1'b0);
        step("R3", 1'b0, 1'b1, 22'h0, 32'h0, 4'h0, '0, 1'b0);
        idle("R3");
        // R8: unmapped read and write
        step("R8", 1'b0, 1'b1, 22'h5, 32'h0, 4'h0, '0, 1'b0);
        step("R8", 1'b0, 1'b0, 22'h7, 32'hDEAD_BEEF, 4'hF, '0, 1'b0);
        step("R8", 1'b0, 1'b1, 22'h7, 32'h0, 4'h0, '0, 1'b0);
        step("R8", 1'b0, 1'b1, 22'h3F_FFFF, 32'h0, 4'h0, '0, 1'b0);
        // R5: events latch and stay
        step("R5", 1'b1, 1'b1, 22'h0, 32'h0, 4'h0, 8'h05, 1'b0);
        idle("R5");
        step("R5", 1'b0, 1'b1, A_STAT, 32'h0, 4'h0, '0, 1'b0);
        // R7: mask write raises irq a cycle later
        step("R7", 1'b0, 1'b0, A_MASK, 32'hFFFF_FF01, 4'b0001, '0, 1'b0);
        idle("R7");
        step("R7", 1'b0, 1'b1, A_MASK, 32'h0, 4'h0, '0, 1'b0);
        // R6: clear with no byte enabled, clear racing an event, plain clear
        step("R6", 1'b0, 1'b0, A_STAT, 32'hFF, 4'h0, '0, 1'b0);
        step("R6", 1'b0, 1'b0, A_STAT, 32'h01, 4'h1, 8'h01, 1'b0);
        step("R6", 1'b0, 1'b1, A_STAT, 32'h0, 4'h0, '0, 1'b0);
        step("R6", 1'b0, 1'b0, A_STAT, 32'h05, 4'h1, '0, 1'b0);
        step("R6", 1'b0, 1'b1, A_STAT, 32'h0, 4'h0, '0, 1'b0);
        idle("R7");
        // R10: synchronous reset discards a coincident read and event
        step("R10", 1'b0, 1'b0, A_MASK, 32'hFF, 4'hF, 8'h10, 1'b0);
        step("R10", 1'b1, 1'b1, 22'h0, 32'h0, 4'h0, 8'h10, 1'b0);
        step("R10", 1'b0, 1'b1, A_STAT, 32'h0, 4'h0, 8'h20, 1'b1);
        step("R10", 1'b0, 1'b1, A_STAT, 32'h0, 4'h0, '0, 1'b0);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [21:0] a;
            int unsigned sel;
            sel = $urandom_range(0, 7);
            case (sel)
                0, 1, 2: a = 22'($urandom_range(0, NC - 1));
                3, 4:    a = A_STAT;
                5:       a = A_MASK;
                default: a = 22'($urandom);
            endcase
            step("R3", 1'($urandom_range(0, 3) == 0), 1'($urandom), a, $urandom,
                 4'($urandom), NE'($urandom_range(0, 3) == 0 ? $urandom : 0),
                 1'($urandom_range(0, 99) == 0));
        end

        // R9: asynchronous reset takes effect without a clock edge
        step("R9", 1'b0, 1'b0, 22'h2, 32'h1357_9BDF, 4'hF, 8'hFF, 1'b0);
        step("R9", 1'b0, 1'b0, A_MASK, 32'hFF, 4'hF, '0, 1'b0);
        step("R9", 1'b0, 1'b1, 22'h2, 32'h0, 4'h0, '0, 1'b0);
        #1 rst_n = 1'b0;
        #1;
        m_clear();
        chk("R9", "rdata", rdata, 32'h0);
        chk("R9", "drv_n", 32'(drv_n), 32'h1);
        chk("R9", "irq_n", 32'(irq_n), 32'h1);
        check_ctrl("R9");
        @(negedge clk);
        rst_n = 1'b1;
        step("R9", 1'b0, 1'b1, A_STAT, 32'h0, 4'h0, '0, 1'b0);
        step("R9", 1'b0, 1'b1, A_MASK, 32'h0, 4'h0, '0, 1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        #(64'd200000 * 8);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule